// File: doc/BRIEF.md
# Two-to-One FIFO Word Packer

The packer joins two FIFOs of different widths. It drains pairs of half-width entries from a source FIFO's read port and writes each pair as one full-width word into a destination FIFO's write port. The earlier entry of a pair becomes the upper half of the word and the later entry becomes the lower half. This matches a stream of alternating left and right samples, where each stored word holds one stereo pair.

Control is kept simple on purpose. A pair transfer begins only when the source already holds two entries, the destination has room, and the previous word has been written. Once a transfer has begun it runs to the end without stalling. The cost is a few idle cycles per word. The source FIFO is assumed to return read data one cycle after its read enable.

Top module: `pair_packer`

## Requirements
- R1: A pair transfer starts only if, in the idle cycle before the first read, the source count is at least 2 and the source empty flag is low. With fewer entries the source is never read.
- R2: Each transfer asserts `src_rd_en` for exactly two consecutive cycles. A new transfer cannot start before the cycle after the previous word's write pulse.
- R3: A transfer starts only if `dst_full` was low in the idle cycle before it. While the destination is full, the source is not read and no word is written.
- R4: The first value read of a pair appears in `dst_wr_data` bits [2*HALF_W-1:HALF_W]. The second value read appears in bits [HALF_W-1:0].
- R5: `dst_wr_en` is a one-cycle pulse that comes two cycles after the second read-enable cycle. This is the cycle right after the second value is captured.
- R6: Read data is sampled one cycle after the read enable that requested it.
- R7: While `rst_n` is low, `src_rd_en` and `dst_wr_en` are low and `dst_wr_data` is zero.
- R8: When the start conditions hold in an idle cycle, `src_rd_en` rises in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| src_count | input | CNT_W | Number of entries stored in the source FIFO |
| src_empty | input | 1 | Source FIFO empty flag |
| src_rd_data | input | HALF_W | Source read data, valid one cycle after a read |
| src_rd_en | output | 1 | Source read enable |
| dst_full | input | 1 | Destination FIFO full flag |
| dst_wr_en | output | 1 | Destination write pulse |
| dst_wr_data | output | 2*HALF_W | Packed word, with the first entry in the upper half |

## Verification
The bench builds the packer with HALF_W=16 and CNT_W=6. It models a destination FIFO only four words deep, so the full flag is reached within a few words and the stall on a full destination can be seen on the ports. A source that holds one entry, or an odd leftover entry, shows the two-entry threshold. Draining the destination on an irregular pattern moves the full flag on and off across transfer boundaries.

// File: rtl/pair_pack_pkg.sv
package pair_pack_pkg;
  localparam int PAIR_ENTRIES = 2;

  typedef enum logic [2:0] {
    PK_IDLE   = 3'd0,
    PK_RD_HI  = 3'd1,
    PK_RD_LO  = 3'd2,
    PK_CAP_LO = 3'd3,
    PK_PUSH   = 3'd4
  } pk_state_t;
endpackage

// File: rtl/pair_pack_ctrl.sv
module pair_pack_ctrl
  import pair_pack_pkg::*;
#(
  parameter int CNT_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] src_count,
  input  logic             src_empty,
  input  logic             dst_full,
  output logic             rd_en,
  output logic [PAIR_ENTRIES-1:0] cap_en,
  output logic             wr_en
);
  localparam logic [CNT_W-1:0] MIN_FILL = CNT_W'(PAIR_ENTRIES);

  pk_state_t state_q, state_d;
  logic      start_ok;

  assign start_ok = (src_count >= MIN_FILL) && !src_empty && !dst_full;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      PK_IDLE:   if (start_ok) state_d = PK_RD_HI;
      PK_RD_HI:  state_d = PK_RD_LO;
      PK_RD_LO:  state_d = PK_CAP_LO;
      PK_CAP_LO: state_d = PK_PUSH;
      PK_PUSH:   state_d = PK_IDLE;
      default:   state_d = PK_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= PK_IDLE;
    else        state_q <= state_d;
  end

  // Upper lane captures the data of the first read, lower lane the second.
  assign rd_en     = (state_q == PK_RD_HI) || (state_q == PK_RD_LO);
  assign cap_en[1] = (state_q == PK_RD_LO);
  assign cap_en[0] = (state_q == PK_CAP_LO);
  assign wr_en     = (state_q == PK_PUSH);
endmodule

// File: rtl/pair_pack_lanes.sv
module pair_pack_lanes
  import pair_pack_pkg::*;
#(
  parameter int HALF_W = 16
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic [PAIR_ENTRIES-1:0]        cap_en,
  input  logic [HALF_W-1:0]              rd_data,
  output logic [PAIR_ENTRIES*HALF_W-1:0] word
);
  for (genvar g = 0; g < PAIR_ENTRIES; g++) begin : g_lane
    logic [HALF_W-1:0] lane_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         lane_q <= '0;
      else if (cap_en[g]) lane_q <= rd_data;
    end

    assign word[g*HALF_W +: HALF_W] = lane_q;
  end
endmodule

// File: rtl/pair_packer.sv
module pair_packer
  import pair_pack_pkg::*;
#(
  parameter int HALF_W = 16,
  parameter int CNT_W  = 6
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [CNT_W-1:0]      src_count,
  input  logic                  src_empty,
  input  logic [HALF_W-1:0]     src_rd_data,
  output logic                  src_rd_en,
  input  logic                  dst_full,
  output logic                  dst_wr_en,
  output logic [2*HALF_W-1:0]   dst_wr_data
);
  logic [PAIR_ENTRIES-1:0] cap_en;

  pair_pack_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .src_count (src_count),
    .src_empty (src_empty),
    .dst_full  (dst_full),
    .rd_en     (src_rd_en),
    .cap_en    (cap_en),
    .wr_en     (dst_wr_en)
  );

  pair_pack_lanes #(.HALF_W(HALF_W)) u_lanes (
    .clk     (clk),
    .rst_n   (rst_n),
    .cap_en  (cap_en),
    .rd_data (src_rd_data),
    .word    (dst_wr_data)
  );
endmodule

// File: rtl/pair_packer_chk.sv
module pair_packer_chk #(
  parameter int HALF_W = 16,
  parameter int CNT_W  = 6
) (
  input logic                clk,
  input logic                rst_n,
  input logic [CNT_W-1:0]    src_count,
  input logic                src_empty,
  input logic [HALF_W-1:0]   src_rd_data,
  input logic                src_rd_en,
  input logic                dst_full,
  input logic                dst_wr_en,
  input logic [2*HALF_W-1:0] dst_wr_data
);
  // R1
  src_two_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(src_rd_en) |-> ($past(src_count) >= 2) && !$past(src_empty));

  // R2
  rd_pair_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(src_rd_en) |=> src_rd_en);

  // R2
  rd_no_third_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (src_rd_en && $past(src_rd_en)) |=> !src_rd_en);

  // R3
  dst_room_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(src_rd_en) |-> !$past(dst_full));

  // R3
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dst_wr_en |-> !dst_full);

  // R4 and R6
  pack_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dst_wr_en |-> (dst_wr_data[2*HALF_W-1:HALF_W] == $past(src_rd_data, 2)) &&
                  (dst_wr_data[HALF_W-1:0] == $past(src_rd_data)));

  // R5
  wr_after_reads_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(src_rd_en) |=> dst_wr_en);

  // R5
  wr_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dst_wr_en |=> !dst_wr_en);

  // R7
  reset_quiet_chk: assert property (@(posedge clk)
    !rst_n |-> !src_rd_en && !dst_wr_en && (dst_wr_data == '0));
endmodule

bind pair_packer pair_packer_chk #(.HALF_W(HALF_W), .CNT_W(CNT_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .src_count   (src_count),
  .src_empty   (src_empty),
  .src_rd_data (src_rd_data),
  .src_rd_en   (src_rd_en),
  .dst_full    (dst_full),
  .dst_wr_en   (dst_wr_en),
  .dst_wr_data (dst_wr_data)
);

// File: tb/pair_packer_bench.sv
`timescale 1ns/1ps
module pair_packer_bench;
  localparam int HALF_W    = 16;
  localparam int CNT_W     = 6;
  localparam int DST_DEPTH = 4;

  logic                clk = 1'b0;
  logic                rst_n = 1'b1;
  logic [CNT_W-1:0]    src_count = '0;
  logic                src_empty = 1'b1;
  logic [HALF_W-1:0]   src_rd_data = '0;
  logic                src_rd_en;
  logic                dst_full = 1'b0;
  logic                dst_wr_en;
  logic [2*HALF_W-1:0] dst_wr_data;

  always #2 clk = ~clk;

  pair_packer #(.HALF_W(HALF_W), .CNT_W(CNT_W)) u_pair_packer (
    .clk(clk), .rst_n(rst_n), .src_count(src_count), .src_empty(src_empty),
    .src_rd_data(src_rd_data), .src_rd_en(src_rd_en), .dst_full(dst_full),
    .dst_wr_en(dst_wr_en), .dst_wr_data(dst_wr_data));

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  logic [HALF_W-1:0]   src_q[$];
  logic [HALF_W-1:0]   pop_log[$];
  logic [2*HALF_W-1:0] dst_q[$];

  logic                push_req = 1'b0;
  logic [HALF_W-1:0]   push_val = '0;
  logic                drain = 1'b0;
  logic                rd_en_s = 1'b0;
  logic                wr_en_s = 1'b0;
  logic [2*HALF_W-1:0] wr_data_s = '0;
  int                  ph = 0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  // Bench-side FIFOs: one-cycle read latency source, small destination.
  always @(posedge clk) begin
    if (rd_en_s) begin
      if (src_q.size() == 0) chk(1'b0, "R1 read of empty source", 32'd0, 32'd1);
      else begin
        logic [HALF_W-1:0] v;
        v = src_q.pop_front();
        src_rd_data <= v;
        pop_log.push_back(v);
      end
    end
    if (push_req) src_q.push_back(push_val);
    if (wr_en_s) begin
      chk(dst_q.size() < DST_DEPTH, "R3 write into full destination",
          dst_q.size(), DST_DEPTH - 1);
      dst_q.push_back(wr_data_s);
    end
    if (drain && dst_q.size() > 0) void'(dst_q.pop_front());
    src_count <= CNT_W'(src_q.size());
    src_empty <= (src_q.size() == 0);
    dst_full  <= (dst_q.size() >= DST_DEPTH);
  end

  // Cycle reference model compared on every clock, away from the active edge.
  always @(negedge clk) begin
    bit exp_rd, exp_wr;
    rd_en_s   = src_rd_en;
    wr_en_s   = dst_wr_en;
    wr_data_s = dst_wr_data;
    exp_rd = (ph == 1) || (ph == 2);
    exp_wr = (ph == 4);
    if (ph == 0) chk(src_rd_en == exp_rd, "R1/R3 idle read gating", src_rd_en, exp_rd);
    else         chk(src_rd_en == exp_rd, "R2 read pair shape", src_rd_en, exp_rd);
    chk(dst_wr_en == exp_wr, "R5 write pulse timing", dst_wr_en, exp_wr);
    if (!rst_n) chk(dst_wr_data == '0, "R7 reset clears word", dst_wr_data, 32'd0);
    if (dst_wr_en) begin
      if (pop_log.size() >= 2) begin
        logic [2*HALF_W-1:0] exp_w;
        exp_w = {pop_log[0], pop_log[1]};
        chk(dst_wr_data == exp_w, "R4 R6 packing order", dst_wr_data, exp_w);
        void'(pop_log.pop_front());
        void'(pop_log.pop_front());
      end else chk(1'b0, "R4 word without two reads", pop_log.size(), 32'd2);
    end
    if (!rst_n) ph = 0;
    else if (ph == 0) begin
      // R8: start follows the first idle cycle with enough data and room.
      if (src_q.size() >= 2 && dst_q.size() < DST_DEPTH) ph = 1;
    end else ph = (ph == 4) ? 0 : ph + 1;
  end

  task automatic push(input logic [HALF_W-1:0] v);
    @(negedge clk);
    push_req = 1'b1;
    push_val = v;
    @(negedge clk);
    push_req = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  initial begin
    #1 rst_n = 1'b0;
    idle(4);
    chk(src_rd_en == 1'b0, "R7 no read in reset", src_rd_en, 1'b0);
    chk(dst_wr_data == '0, "R7 word zero in reset", dst_wr_data, 32'd0);
    rst_n = 1'b1;
    drain = 1'b1;
    // R1: a single entry is never read.
    push(16'hA001);
    idle(10);
    chk(src_count == 1, "R1 lone entry left in source", src_count, 32'd1);
    push(16'hA002);
    idle(10);
    chk(dst_q.size() == 0, "R4 first word drained", dst_q.size(), 32'd0);
    // Back-to-back stream of pairs.
    for (int i = 0; i < 10; i++) push(16'hB000 + 16'(i));
    idle(30);
    // R3: destination fills, reading stops.
    drain = 1'b0;
    for (int i = 0; i < 14; i++) push(16'hC100 + 16'(i));
    idle(40);
    chk(dst_full == 1'b1, "R3 destination full", dst_full, 1'b1);
    chk(src_count == 6, "R3 reads paused while full", src_count, 32'd6);
    drain = 1'b1;
    idle(40);
    // Odd leftover entry stays behind.
    for (int i = 0; i < 3; i++) push(16'hD200 + 16'(i));
    idle(20);
    chk(src_count == 1, "R1 odd leftover kept", src_count, 32'd1);
    // Irregular drain pattern across transfers.
    for (int i = 0; i < 40; i++) begin
      drain = (i % 3) != 0;
      push(16'hE300 + 16'(i));
    end
    drain = 1'b1;
    idle(60);
    chk(src_count <= 1, "R2 source drained to under a pair", src_count, 32'd1);
    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      summary();
      $finish;
    end
  end
endmodule